// File: doc/BRIEF.md
# Write-Through Invalidating Snoop Cache Node

This block is the cache controller for one processor node on a small shared-bus multiprocessor. It keeps a direct-mapped array of lines, each holding one data word, a tag and a single valid bit. A line is either valid or invalid, and a line that was never filled counts as invalid. Loads that hit are answered locally in the cycle they are presented. Loads that miss fetch the word over the bus and fill the line. Every store goes out on the bus as a write-through. A store that hits also refreshes the local copy. A store that misses does not allocate a line.

The node competes for the bus through a request/grant pair and holds its command, address and data steady until the responder acknowledges. It also watches the transactions that other nodes place on the bus. When another node writes a word that this node holds, the local line is dropped, so every cache sees the writes in bus order. The snoop lookup shares the tag array with the CPU. If a snoop and a CPU access arrive in the same cycle, the snoop is served first and the CPU is stalled for that cycle.

Top module: `wtinv_node`

## Requirements
- R1: After reset every line is invalid, `bus_req` and `cpu_ready` are low, and the first load of any address goes to the bus.
- R2: A load that hits a valid line with a matching tag raises `cpu_ready` in the same cycle it is presented, with the line's word on `cpu_rdata`, and raises no bus request.
- R3: A load that misses raises `bus_req` with `bus_we`=0 in the next cycle. It completes in the cycle where `bus_gnt` and `bus_ack` are both high, returns `bus_rdata`, and leaves the line valid with the new tag and word.
- R4: Every store raises `bus_req` with `bus_we`=1 and the store's address and data. It completes only in a cycle where `bus_gnt` and `bus_ack` are both high.
- R5: A store that hits updates the local word, so a later load hits and returns the stored value. A store that misses leaves the array unchanged, so a later load of that address misses.
- R6: While `bus_req` is high and the transaction has not been acknowledged, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values.
- R7: A snooped write (`snp_valid`=1, `snp_we`=1) whose address matches a valid line makes that line invalid at the end of that cycle, so the next load of that address misses and fetches the new value.
- R8: A snooped read (`snp_we`=0), and a snooped write to the same index with a different tag, leave the line valid with its contents unchanged.
- R9: In any cycle with `snp_valid` high, the node accepts no new CPU access and `cpu_ready` stays low. The access is taken in the next free cycle.
- R10: A snooped write that arrives while this node waits for the grant takes effect before this node's own transaction. A pending store then reaches memory after it and does not re-validate the line, and a pending load returns the snooped value.
- Addresses are word addresses. The index is the low log2(LINES) bits and the tag is the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | DW | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DW | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | Bus command: 1 = write, 0 = read |
| bus_addr | output | AW | Bus word address |
| bus_wdata | output | DW | Bus write data |
| bus_gnt | input | 1 | Bus granted to this node |
| bus_ack | input | 1 | Responder completes the granted transaction |
| bus_rdata | input | DW | Read data from the responder |
| snp_valid | input | 1 | Another node's transaction is on the bus |
| snp_we | input | 1 | Snooped command: 1 = write |
| snp_addr | input | AW | Snooped word address |

## Verification
The assertions assume a well-behaved environment. The CPU holds its request and operands steady until `cpu_ready`. `bus_ack` occurs only with `bus_gnt`. Because the bus is atomic, no snoop is presented in a cycle when this node holds the grant. The bench's arbiter grants a request only after it has been registered and acknowledges in the grant cycle. Snoops are injected only while the node is idle or still waiting for its grant, never while it owns the bus.

// File: rtl/wtinv_node.sv
module wtinv_node #(
  parameter int LINES = 16,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  input  logic          snp_valid,
  input  logic          snp_we,
  input  logic [AW-1:0] snp_addr
);
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TW = AW - IW;

  logic [LINES-1:0] vld;
  logic [TW-1:0]    tags [LINES];
  logic [DW-1:0]    words[LINES];

  logic          busy;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  wire [IW-1:0] c_idx = cpu_addr[IW-1:0];
  wire [TW-1:0] c_tag = cpu_addr[AW-1:IW];
  wire [IW-1:0] s_idx = snp_addr[IW-1:0];
  wire [TW-1:0] s_tag = snp_addr[AW-1:IW];
  wire [IW-1:0] q_idx = addr_q[IW-1:0];
  wire [TW-1:0] q_tag = addr_q[AW-1:IW];

  wire c_hit  = vld[c_idx] && (tags[c_idx] == c_tag);
  wire q_hit  = vld[q_idx] && (tags[q_idx] == q_tag);
  wire s_kill = snp_valid && snp_we && vld[s_idx] && (tags[s_idx] == s_tag);

  wire accept = !busy && cpu_req && !snp_valid;
  wire rd_hit = accept && !cpu_we && c_hit;
  wire go_bus = accept && (cpu_we || !c_hit);
  wire done   = busy && bus_gnt && bus_ack;

  assign cpu_ready = rd_hit || done;
  assign cpu_rdata = busy ? bus_rdata : words[c_idx];
  assign bus_req   = busy;
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      vld     <= '0;
    end else begin
      if (go_bus) begin
        busy    <= 1'b1;
        we_q    <= cpu_we;
        addr_q  <= cpu_addr;
        wdata_q <= cpu_wdata;
      end
      if (done) begin
        busy <= 1'b0;
        if (!we_q) begin
          vld[q_idx]   <= 1'b1;
          tags[q_idx]  <= q_tag;
          words[q_idx] <= bus_rdata;
        end else if (q_hit) begin
          words[q_idx] <= wdata_q;
        end
      end
      if (s_kill) vld[s_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/wtinv_node_chk.sv
module wtinv_node_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic          cpu_ready,
  input logic [DW-1:0] cpu_rdata,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_gnt,
  input logic          bus_ack,
  input logic [DW-1:0] bus_rdata,
  input logic          snp_valid
);
  assert_local_done_is_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && !bus_req |-> !cpu_we);

  assert_fill_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && bus_req && !cpu_we |-> cpu_rdata == bus_rdata);

  assert_bus_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(cpu_req) && !$past(snp_valid));

  assert_store_needs_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_we |-> bus_req && bus_we && bus_gnt && bus_ack);

  assert_request_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !(bus_gnt && bus_ack) |=>
      bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

  assert_snoop_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !bus_req |-> !cpu_ready);
endmodule

bind wtinv_node wtinv_node_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
  .snp_valid(snp_valid)
);

// File: tb/wtinv_node_tb.sv
module wtinv_node_tb;
  localparam int LINES = 4;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_gnt = 1'b0;
  logic bus_ack;
  logic [DW-1:0] bus_rdata;
  logic snp_valid = 1'b0, snp_we = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic hold_off = 1'b0;

  logic [DW-1:0] mem [NW];
  logic          mv  [LINES];
  logic [3:0]    mt  [LINES];
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  assign bus_ack   = bus_gnt;
  assign bus_rdata = mem[bus_addr];

  always @(posedge clk) begin
    if (!rst_n) bus_gnt <= 1'b0;
    else        bus_gnt <= bus_req && !bus_gnt && !hold_off;
  end

  wtinv_node #(.LINES(LINES), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .snp_valid(snp_valid),
    .snp_we(snp_we), .snp_addr(snp_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_snoop(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (we) begin
      mem[a] = d;
      if (mv[a[1:0]] && mt[a[1:0]] == a[5:2]) mv[a[1:0]] = 1'b0;
    end
  endtask

  task automatic snoop(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    model_snoop(we, a, d);
    snp_valid = 1'b1; snp_we = we; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input int mode, input logic swe, input logic [AW-1:0] sa,
                    output logic [DW-1:0] rd, output int cyc, output bit sb, output bit bad);
    bit fin;
    fin = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = d;
    cyc = 0; sb = 1'b0; bad = 1'b0; rd = '0;
    if (mode == 1) begin snp_valid = 1'b1; snp_we = swe; snp_addr = sa; end
    if (mode == 2) hold_off = 1'b1;
    while (!fin) begin
      #1;
      if (bus_req) begin
        sb = 1'b1;
        if (bus_addr !== a || bus_we !== w || (w && bus_wdata !== d)) bad = 1'b1;
      end
      cyc++;
      if (cpu_ready === 1'b1) begin rd = cpu_rdata; fin = 1'b1; end
      if (cyc > 40) fin = 1'b1;
      @(negedge clk);
      snp_valid = 1'b0;
      if (mode == 2 && cyc == 1) begin snp_valid = 1'b1; snp_we = swe; snp_addr = sa; end
      if (mode == 2 && cyc == 2) hold_off = 1'b0;
    end
    cpu_req = 1'b0;
    hold_off = 1'b0;
  endtask

  task automatic do_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int mode, input logic swe, input logic [AW-1:0] sa,
                       input logic [DW-1:0] sd, input string tag, output bit sb);
    logic [DW-1:0] rd;
    int cyc, ecyc;
    bit bad, hit;
    if (mode == 1) model_snoop(swe, sa, sd);
    hit = mv[a[1:0]] && mt[a[1:0]] == a[5:2];
    if (mode == 2) model_snoop(swe, sa, sd);
    op(w, a, d, mode, swe, sa, rd, cyc, sb, bad);
    if (!w && hit) ecyc = (mode == 1) ? 2 : 1;
    else           ecyc = (mode == 0) ? 3 : 4;
    chk(cyc == ecyc, (!w && hit) ? "R2" : (w ? "R4" : "R3"), "cycles to ready", cyc, ecyc);
    chk(sb == (w || !hit), (!w && hit) ? "R2" : (w ? "R4" : "R3"), "bus used", sb, w || !hit);
    chk(!bad, "R6", "bus command/address/data", a, a);
    if (!w) begin
      chk(rd === mem[a], tag, "load data", rd, mem[a]);
      if (!hit) begin mv[a[1:0]] = 1'b1; mt[a[1:0]] = a[5:2]; end
    end else begin
      mem[a] = d;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit sb;
    for (int i = 0; i < NW; i++) mem[i] = 32'h1000_0000 + i * 32'h0001_0003;
    for (int i = 0; i < LINES; i++) begin mv[i] = 1'b0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    chk(cpu_ready == 1'b0, "R1", "cpu_ready in reset", cpu_ready, 0);
    chk(bus_req == 1'b0, "R1", "bus_req in reset", bus_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_req == 1'b0, "R1", "bus_req after reset", bus_req, 0);

    // R1/R2/R3: every address loaded twice
    for (int i = 0; i < NW; i++) begin
      do_op(1'b0, i[AW-1:0], '0, 0, 1'b0, '0, '0, "R3", sb);
      if (i < LINES) chk(sb, "R1", "first load after reset on bus", sb, 1);
      do_op(1'b0, i[AW-1:0], '0, 0, 1'b0, '0, '0, "R2", sb);
    end

    // R4/R5: store hit then store miss (same index, other tag)
    for (int i = 0; i < NW; i++) begin
      logic [AW-1:0] a, j;
      a = i[AW-1:0];
      j = a ^ 6'd32;
      do_op(1'b0, a, '0, 0, 1'b0, '0, '0, "R3", sb);
      do_op(1'b1, a, 32'hC000_0000 ^ (i * 32'h0101_0101), 0, 1'b0, '0, '0, "R4", sb);
      do_op(1'b0, a, '0, 0, 1'b0, '0, '0, "R5", sb);
      chk(!sb, "R5", "load after store hit stays local", sb, 0);
      do_op(1'b1, j, 32'h5A00_0000 + i, 0, 1'b0, '0, '0, "R4", sb);
      do_op(1'b0, j, '0, 0, 1'b0, '0, '0, "R5", sb);
      chk(sb, "R5", "load after store miss goes to bus", sb, 1);
    end

    // R7/R8: snoops while idle
    for (int i = 0; i < NW; i++) begin
      logic [AW-1:0] a;
      a = i[AW-1:0];
      do_op(1'b0, a, '0, 0, 1'b0, '0, '0, "R3", sb);
      snoop(1'b0, a, '0);
      do_op(1'b0, a, '0, 0, 1'b0, '0, '0, "R8", sb);
      chk(!sb, "R8", "snooped read keeps line", sb, 0);
      snoop(1'b1, a ^ 6'd16, 32'h7700_0000 + i);
      do_op(1'b0, a, '0, 0, 1'b0, '0, '0, "R8", sb);
      chk(!sb, "R8", "snooped write other tag keeps line", sb, 0);
      snoop(1'b1, a, 32'h3300_0000 + i);
      do_op(1'b0, a, '0, 0, 1'b0, '0, '0, "R7", sb);
      chk(sb, "R7", "snooped write hit forces refetch", sb, 1);
    end

    // R9: snoop collides with a CPU access
    for (int i = 0; i < NW; i += 5) begin
      logic [AW-1:0] a;
      a = i[AW-1:0];
      do_op(1'b0, a, '0, 0, 1'b0, '0, '0, "R3", sb);
      do_op(1'b0, a, '0, 1, 1'b0, a ^ 6'd8, '0, "R9", sb);
      do_op(1'b0, a, '0, 1, 1'b1, a, 32'h9900_0000 + i, "R9", sb);
      chk(sb, "R9", "collided snoop write applied first", sb, 1);
    end

    // R10: snooped write while waiting for the grant
    for (int i = 0; i < NW; i += 3) begin
      logic [AW-1:0] a, k;
      a = i[AW-1:0];
      k = a ^ 6'd36;
      do_op(1'b0, a, '0, 0, 1'b0, '0, '0, "R3", sb);
      do_op(1'b1, a, 32'hEE00_0000 + i, 2, 1'b1, a, 32'h1100_0000 + i, "R10", sb);
      do_op(1'b0, a, '0, 0, 1'b0, '0, '0, "R10", sb);
      chk(sb, "R10", "line invalid after snoop then own store", sb, 1);
      do_op(1'b0, k, '0, 2, 1'b1, k, 32'h2200_0000 + i, "R10", sb);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule